// File: doc/BRIEF.md
# Multilevel staircase gate sequencer

The block drives the four complementary switch pairs of one phase limb of a four-cell, five-level flying-capacitor inverter. It produces a staircase with one step per level. A phase accumulator advances by `phase_inc` every clock, and a full turn of the accumulator is one fundamental cycle. Two angles set where the staircase steps. These angles are normally chosen to fix the fundamental and cancel the fifth harmonic. The steps repeat, mirrored, in all four quarters of the odd waveform. Each pair switches once per fundamental cycle, and only one pair moves at any step.

Every intermediate level can be produced by several switch states. The block rotates through a four-entry balancing table, so that successive fundamental cycles use different states at the same level. This lets each flying capacitor see matched charge and discharge over four cycles, with no voltage feedback. A table entry is a chain of three states, one each for −0.5, 0 and +0.5. The entry is latched while the limb sits at the −1 plateau. It then serves the whole rise to +1 and the fall back to −1, which run through the same states in reverse order. New angle values are accepted only at the accumulator wrap.

Top module: `stair_gate_seq`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, makes `gate_state` 0000 and `cycle_idx` 0 after that edge. It also clears the phase accumulator to 0.
- R2: After k clocks out of reset with constant `phase_inc`, the phase is p = k·phase_inc mod F, with F = 2^PHASE_W and H = F/2. Let a1 ≤ a2 ≤ F/4 be the active angles. The level index (number of ones in `gate_state` once armed) is: 2 for p < a1; 3 for p < a2; 4 for p < H−a2; 3 for p < H−a1; 2 for p < H+a1; 1 for p < H+a2; 0 for p < F−a2; 1 for p < F−a1; and 2 otherwise.
- R3: Bit 3 of `gate_state` drives the pair nearest the DC link, and a 1 means the upper switch of a pair conducts. Level index 0 (−1) gives 0000 and level index 4 (+1) gives 1111. The other levels come from table entry s, which is `pattern[12s+11:12s]`. Within an entry, bits [3:0] give the state for −0.5, bits [7:4] for 0 and bits [11:8] for +0.5.
- R4: `cycle_idx` increments by one, modulo 4, on the clock where phase + `phase_inc` carries out of PHASE_W bits. It changes on no other clock.
- R5: While the level index is 0, the selected entry is set to (`cycle_idx` + 1) mod 4. The entry then holds until the next −1 plateau. So the positive half of fundamental cycle c uses entry c, and the descent after the +1 plateau replays that entry's states in reverse.
- R6: After reset, `gate_state` stays 0000 until the phase first reaches the −1 plateau.
- R7: Reset loads angles of about 26.13° and 60.97°, each equal to floor(millidegrees·F/360000). `angle_lo` and `angle_hi` are copied into the active angles only on the wrap clock, and that clock already uses the copied values.
- R8: With a valid chained table and `phase_inc` smaller than every level interval, each change of `gate_state` flips exactly one bit.
- R9: Under the same conditions as R8, each change of `gate_state` moves the level index by exactly one.
- R10: With a2 = F/4, the +1 level never occurs, and the limb turns back from +0.5 at the quarter point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_inc | input | PHASE_W | Phase advance per clock; F is one fundamental cycle |
| angle_lo | input | PHASE_W | First step angle, taken at the wrap |
| angle_hi | input | PHASE_W | Second step angle, taken at the wrap |
| pattern | input | 48 | Four balancing entries of three 4-bit states |
| gate_state | output | 4 | Registered switch-pair states, MSB outermost |
| cycle_idx | output | 2 | Index of the current fundamental cycle within the pattern |

## Verification
The accumulator wrap does three things in one clock: it advances the cycle index, reloads the angles and evaluates a level with the freshly loaded angles. A separate coincidence happens when the limb enters the −1 plateau: the balancing entry is latched in the same clock as the state lookup that depends on it. The angle inputs are changed partway through a cycle. Samples then fall just before and just after the following wrap, at phases where the old and new angles give different levels. The table entry is also probed in the −0.5 region on both sides of the plateau. Each sample is judged against an arithmetic model that tracks the phase, cycle, arming and entry selection from the requirements alone.

// File: rtl/stair_pkg.sv
package stair_pkg;
    localparam int NCELL  = 4;                 // switch pairs per limb
    localparam int NLEVEL = NCELL + 1;         // output levels
    localparam int NMID   = NCELL - 1;         // levels with redundant states
    localparam int NSEQ   = NCELL;             // entries in a balancing pattern
    localparam int SEQ_W  = NMID * NCELL;      // bits per entry
    localparam int PAT_W  = NSEQ * SEQ_W;      // bits per pattern
    localparam int LVL_W  = $clog2(NLEVEL);
    localparam int CYC_W  = $clog2(NSEQ);
    localparam int MID_IW = $clog2(NMID);

    typedef logic [NCELL-1:0] gate_t;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [CYC_W-1:0] cyc_t;
endpackage

// File: rtl/stair_phase_acc.sv
module stair_phase_acc
    import stair_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int A1_MDEG = 26130,
    parameter int A2_MDEG = 60970
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_inc,
    input  logic [PHASE_W-1:0] angle_lo,
    input  logic [PHASE_W-1:0] angle_hi,
    output logic [PHASE_W-1:0] phase_nx,
    output logic [PHASE_W-1:0] a1_nx,
    output logic [PHASE_W-1:0] a2_nx,
    output cyc_t               cyc_nx,
    output cyc_t               cyc_cur
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam longint A1_L = (longint'(A1_MDEG) << PHASE_W) / 360000;
    localparam longint A2_L = (longint'(A2_MDEG) << PHASE_W) / 360000;
    localparam logic [PHASE_W-1:0] DEF_A1 = PHASE_W'(A1_L);
    localparam logic [PHASE_W-1:0] DEF_A2 = PHASE_W'(A2_L);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [PHASE_W-1:0] a1;
        logic [PHASE_W-1:0] a2;
        cyc_t               cyc;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [PHASE_W:0] sum;

    always_comb begin
        acc_d     = acc_q;
        sum       = {1'b0, acc_q.phase} + {1'b0, phase_inc};
        acc_d.phase = sum[PHASE_W-1:0];
        if (sum[PHASE_W]) begin
            acc_d.cyc = acc_q.cyc + cyc_t'(1);
            acc_d.a1  = angle_lo;
            acc_d.a2  = angle_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q.phase <= '0;
            acc_q.a1    <= DEF_A1;
            acc_q.a2    <= DEF_A2;
            acc_q.cyc   <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign phase_nx = acc_d.phase;
    assign a1_nx    = acc_d.a1;
    assign a2_nx    = acc_d.a2;
    assign cyc_nx   = acc_d.cyc;
    assign cyc_cur  = acc_q.cyc;
endmodule

// File: rtl/stair_level_map.sv
module stair_level_map
    import stair_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input  logic [PHASE_W-1:0] phase,
    input  logic [PHASE_W-1:0] a1,
    input  logic [PHASE_W-1:0] a2,
    output lvl_t               level
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [PHASE_W-1:0] HALF    = {1'b1, {(PHASE_W-1){1'b0}}};
    localparam lvl_t               MID_LVL = lvl_t'(NCELL / 2);

    logic [PHASE_W-1:0] x_in_half;
    logic [PHASE_W-1:0] x_mirror;
    logic               neg_half;
    logic               late_quarter;
    logic [1:0]         mag;

    always_comb begin
        neg_half     = phase[PHASE_W-1];
        late_quarter = phase[PHASE_W-2];
        x_in_half    = {1'b0, phase[PHASE_W-2:0]};
        x_mirror     = HALF - x_in_half;
        if (!late_quarter) begin
            // rising edge of the half wave: steps taken at a1, a2
            if (x_in_half >= a2)      mag = 2'd2;
            else if (x_in_half >= a1) mag = 2'd1;
            else                      mag = 2'd0;
        end else begin
            // falling edge: steps at the mirrored angles
            if (x_mirror > a2)        mag = 2'd2;
            else if (x_mirror > a1)   mag = 2'd1;
            else                      mag = 2'd0;
        end
        level = neg_half ? (MID_LVL - lvl_t'(mag)) : (MID_LVL + lvl_t'(mag));
    end
endmodule

// File: rtl/stair_pattern_sel.sv
module stair_pattern_sel
    import stair_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lvl_t             level_nx,
    input  cyc_t             cyc_nx,
    input  logic [PAT_W-1:0] pattern,
    output gate_t            gate_cur
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam lvl_t TOP_LVL = lvl_t'(NCELL);

    typedef struct packed {
        logic  armed;
        cyc_t  sel;
        gate_t gate;
    } sel_t;

    sel_t sel_d, sel_q;
    gate_t tbl [NSEQ][NMID];
    lvl_t  mid_full;
    logic [MID_IW-1:0] mid_idx;

    for (genvar s = 0; s < NSEQ; s++) begin : g_seq
        for (genvar m = 0; m < NMID; m++) begin : g_mid
            assign tbl[s][m] = pattern[s*SEQ_W + m*NCELL +: NCELL];
        end
    end

    always_comb begin
        sel_d    = sel_q;
        mid_full = level_nx - lvl_t'(1);
        mid_idx  = mid_full[MID_IW-1:0];
        if (level_nx == '0) begin
            // bottom plateau: the only point where no redundant state is in use
            sel_d.armed = 1'b1;
            sel_d.sel   = cyc_nx + cyc_t'(1);
        end
        if (!sel_d.armed || level_nx == '0) begin
            sel_d.gate = '0;
        end else if (level_nx >= TOP_LVL) begin
            sel_d.gate = '1;
        end else begin
            sel_d.gate = tbl[sel_d.sel][mid_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign gate_cur = sel_q.gate;
endmodule

// File: rtl/stair_gate_seq.sv
module stair_gate_seq
    import stair_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int A1_MDEG = 26130,
    parameter int A2_MDEG = 60970
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_inc,
    input  logic [PHASE_W-1:0] angle_lo,
    input  logic [PHASE_W-1:0] angle_hi,
    input  logic [PAT_W-1:0]   pattern,
    output logic [NCELL-1:0]   gate_state,
    output logic [CYC_W-1:0]   cycle_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [PHASE_W-1:0] phase_nx;
    logic [PHASE_W-1:0] a1_nx;
    logic [PHASE_W-1:0] a2_nx;
    cyc_t               cyc_nx;
    cyc_t               cyc_cur;
    lvl_t               level_nx;
    gate_t              gate_cur;

    stair_phase_acc #(
        .PHASE_W (PHASE_W),
        .A1_MDEG (A1_MDEG),
        .A2_MDEG (A2_MDEG)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .phase_inc (phase_inc),
        .angle_lo  (angle_lo),
        .angle_hi  (angle_hi),
        .phase_nx  (phase_nx),
        .a1_nx     (a1_nx),
        .a2_nx     (a2_nx),
        .cyc_nx    (cyc_nx),
        .cyc_cur   (cyc_cur)
    );

    stair_level_map #(
        .PHASE_W (PHASE_W)
    ) u_map (
        .phase (phase_nx),
        .a1    (a1_nx),
        .a2    (a2_nx),
        .level (level_nx)
    );

    stair_pattern_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .level_nx (level_nx),
        .cyc_nx   (cyc_nx),
        .pattern  (pattern),
        .gate_cur (gate_cur)
    );

    assign gate_state = gate_cur;
    assign cycle_idx  = cyc_cur;
endmodule

// File: rtl/stair_gate_seq_chk.sv
module stair_gate_seq_chk
    import stair_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NCELL-1:0] gate_state,
    input logic [CYC_W-1:0] cycle_idx
);
    timeunit 1ns;
    timeprecision 1ps;

    // R1: the cycle after reset is released, outputs show the reset values
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gate_state == '0 && cycle_idx == '0));

    // R4: cycle index only ever steps forward by one
    assert_cycle_step_R4: assert property (@(posedge clk) disable iff (rst)
        (cycle_idx != $past(cycle_idx)) |-> (cycle_idx == $past(cycle_idx) + 2'd1));

    // R8: one switch pair per transition
    assert_single_pair_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(gate_state ^ $past(gate_state)) <= 1);

    // R9: level moves by exactly one step when the state changes
    assert_level_step_R9: assert property (@(posedge clk) disable iff (rst)
        (gate_state != $past(gate_state)) |->
            (($countones(gate_state) == $countones($past(gate_state)) + 1) ||
             ($countones(gate_state) + 1 == $countones($past(gate_state)))));
endmodule

bind stair_gate_seq stair_gate_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .gate_state (gate_state),
    .cycle_idx  (cycle_idx)
);

// File: tb/stair_gate_seq_test.sv
module stair_gate_seq_test;
    import stair_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PW   = 16;
    localparam int FULL = 1 << PW;
    localparam int HALF = FULL / 2;
    localparam int DA1  = int'((longint'(26130) << PW) / 360000);
    localparam int DA2  = int'((longint'(60970) << PW) / 360000);
    localparam logic [PAT_W-1:0] PAT_DEF = 48'hB98_DC4_E62_731;
    localparam logic [PAT_W-1:0] PAT_ALT = 48'hD51_EC4_BA8_732;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PW-1:0]    inc  = 16'd64;
    logic [PW-1:0]    alo  = PW'(DA1);
    logic [PW-1:0]    ahi  = PW'(DA2);
    logic [PAT_W-1:0] pat  = PAT_DEF;
    logic [NCELL-1:0] gs;
    logic [CYC_W-1:0] ci;

    always #4 clk = ~clk;

    stair_gate_seq #(.PHASE_W(PW)) uut (
        .clk        (clk),
        .rst        (rst),
        .phase_inc  (inc),
        .angle_lo   (alo),
        .angle_hi   (ahi),
        .pattern    (pat),
        .gate_state (gs),
        .cycle_idx  (ci)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int nib(logic [PAT_W-1:0] p, int s, int k);
        return int'(p[s*SEQ_W + k*NCELL +: NCELL]);
    endfunction

    function automatic int exp_level(int p, int a1, int a2);
        if (p < a1)        return 2;
        if (p < a2)        return 3;
        if (p < HALF - a2) return 4;
        if (p < HALF - a1) return 3;
        if (p < HALF + a1) return 2;
        if (p < HALF + a2) return 1;
        if (p < FULL - a2) return 0;
        if (p < FULL - a1) return 1;
        return 2;
    endfunction

    // reference model built from the requirements
    int tick, mph, mcyc, msel, ma1, ma2, mexp, lv;
    bit marm;
    always @(posedge clk) begin
        if (rst) begin
            tick = 0; mph = 0; mcyc = 0; msel = 0; marm = 0;
            ma1 = DA1; ma2 = DA2; mexp = 0;
        end else begin
            tick++;
            mph += int'(inc);
            if (mph >= FULL) begin
                mph -= FULL;
                mcyc = (mcyc + 1) % NSEQ;
                ma1 = int'(alo);
                ma2 = int'(ahi);
            end
            lv = exp_level(mph, ma1, ma2);
            if (lv == 0) begin
                marm = 1;
                msel = (mcyc + 1) % NSEQ;
            end
            if (!marm || lv == 0) mexp = 0;
            else if (lv == 4)     mexp = 15;
            else                  mexp = nib(pat, msel, lv - 1);
        end
    end

    bit    mon_en = 0;
    string mon_tag = "R2";
    logic [NCELL-1:0] prev_gs = '0;
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            check({mon_tag, " gate_state"}, int'(gs), mexp);
            check({"R4 cycle_idx (", mon_tag, ")"}, int'(ci), mcyc);
            if (gs != prev_gs) begin
                check("R8 one pair per step", $countones(gs ^ prev_gs), 1);
                check("R9 one level per step",
                      ($countones(gs) > $countones(prev_gs)) ?
                      $countones(gs) - $countones(prev_gs) :
                      $countones(prev_gs) - $countones(gs), 1);
            end
        end
        prev_gs = gs;
    end

    task automatic at_tick(int t);
        while (tick < t) @(negedge clk);
    endtask

    // explicit probes at known angles for phase_inc = 64 (1024 clocks per cycle)
    task automatic run_cycles(int ncyc);
        for (int m = 0; m < ncyc; m++) begin
            int b  = 1024 * m;
            int c  = m % NSEQ;
            int cn = (m + 1) % NSEQ;
            at_tick(b + 128);   // 45 deg, +0.5
            check(m == 0 ? "R6 idle before first bottom plateau" : "R5 +0.5 state of this cycle",
                  int'(gs), m == 0 ? 0 : nib(pat, c, 2));
            at_tick(b + 256);   // 90 deg, +1
            check(m == 0 ? "R6 idle at top before arming" : "R3 +1 plateau all ones",
                  int'(gs), m == 0 ? 0 : 15);
            at_tick(b + 512);   // 180 deg, 0
            check("R5 zero state of this cycle", int'(gs), m == 0 ? 0 : nib(pat, c, 1));
            at_tick(b + 640);   // 225 deg, -0.5
            check("R5 descent replays entry", int'(gs), m == 0 ? 0 : nib(pat, c, 0));
            at_tick(b + 768);   // 270 deg, -1
            check("R3 -1 plateau all zeros", int'(gs), 0);
            at_tick(b + 896);   // 315 deg, -0.5 of next entry
            check("R5 next entry latched at bottom", int'(gs), nib(pat, cn, 0));
            at_tick(b + 1024);  // wrap
            check("R4 cycle index after wrap", int'(ci), cn);
        end
    endtask

    initial begin
        int nfull;
        repeat (3) @(negedge clk);
        check("R1 reset gate_state", int'(gs), 0);
        check("R1 reset cycle_idx", int'(ci), 0);
        rst = 1'b0;
        mon_en = 1;
        mon_tag = "R2";
        run_cycles(5);

        // angle change partway through a cycle
        mon_tag = "R7";
        at_tick(5120 + 100);
        alo = 16'd3641;
        ahi = 16'd9102;
        at_tick(5120 + 150);
        check("R7 old angles until wrap", int'(gs), nib(pat, 1, 2));
        at_tick(6144 + 60);
        check("R7 new a1 after wrap", int'(gs), nib(pat, 2, 2));
        at_tick(6144 + 150);
        check("R7 new a2 after wrap", int'(gs), 15);

        // reset while at the +1 plateau
        at_tick(6144 + 256);
        rst = 1'b1;
        alo = PW'(DA1);
        ahi = PW'(DA2);
        pat = PAT_ALT;
        @(negedge clk);
        check("R1 mid-run reset gate_state", int'(gs), 0);
        check("R1 mid-run reset cycle_idx", int'(ci), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mon_tag = "R3";
        run_cycles(5);

        // quarter-wave second angle, faster increment
        rst = 1'b1;
        inc = 16'd100;
        alo = 16'd5461;
        ahi = 16'd16384;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mon_tag = "R10";
        at_tick(700);
        nfull = 0;
        while (tick < 4000) begin
            @(negedge clk);
            if (gs == 4'hF) nfull++;
        end
        check("R10 no +1 level with quarter angle", nfull, 0);

        mon_en = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule